// File: doc/BRIEF.md
# Polyphase Scaler Phase Generator

This block walks one scaling direction of a polyphase resampler. For every output sample it reports which source sample the filter centres on and which of 64 sub-sample phases should pick the filter coefficients. It works from a fixed-point step ratio with 3 integer and 24 fraction bits and a starting position split into an integer part and a 24-bit fraction. Software writes these through a narrow register port. Writes to the five least significant fraction bits are discarded, so positions move in steps of 2^-19.

There are two ratio registers, one per colour plane (luma and chroma). There are four start-position registers, one per plane and per interlaced field (top and bottom). A start pulse selects a plane and a field. On the next clock edge the accumulator loads the chosen start position and the block captures that plane's ratio for the rest of the line. After that, each step strobe adds the captured ratio once. A one-cycle flag marks every step that moves the integer source position. The filter arithmetic, the coefficient store and the line buffer all sit downstream of this block.

Top module: `scaler_phase_gen`

## Requirements
- R1: While reset is held and right after it is released, `src_idx_o`, `phase_o`, `advance_o` and `active_o` are all 0.
- R2: Bits 4:0 of every stored ratio and every stored start fraction always read as zero, whatever value was written. A ratio written as 0x000001F therefore does not move the position.
- R3: A start pulse causes the next edge to load the selected start position and set `active_o`. From that edge the outputs describe output sample 0.
- R4: A step while active adds the captured ratio to the position. `advance_o` is high for exactly the cycle after a step whose integer position changed. With no step and no start, the outputs hold.
- R5: The phase is bits 23:18 of (fraction + 2^17). If that sum reaches 1.0, the phase is 0 and `src_idx_o` is the integer position plus one. Otherwise `src_idx_o` is the integer position.
- R6: The register map is as follows. Address 0 is the luma ratio and address 1 is the chroma ratio; ratio data sits in bits 26:0 as 3.24. Addresses 2, 3, 4 and 5 are the start positions for luma top, luma bottom, chroma top and chroma bottom; start data is the integer in bits 27:24 and the fraction in bits 23:0. A start with `sel_chroma_i` = 1 uses the chroma registers, and `sel_bottom_i` = 1 uses the bottom-field start.
- R7: When start and step arrive in the same cycle, the start wins and the step is dropped (`advance_o` = 0, outputs show sample 0).
- R8: A step while not active changes no output.
- R9: Writes to addresses 6 and 7 change no register.
- R10: A write in the same cycle as a start is not seen by that start. A ratio written in the middle of a line takes effect only at the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 28 | Register write data |
| start_i | input | 1 | Begin a line with the selected registers |
| sel_chroma_i | input | 1 | Plane select at start: 0 luma, 1 chroma |
| sel_bottom_i | input | 1 | Field select at start: 0 top, 1 bottom |
| step_i | input | 1 | Advance by one output sample |
| src_idx_o | output | 16 | Rounded integer source position |
| phase_o | output | 6 | Filter phase index, 0 to 63 |
| advance_o | output | 1 | Integer position moved on the last step |
| active_o | output | 1 | A line has been started |

## Verification
Three pairs of events can meet in one clock cycle. A line start and a step strobe can coincide. A line start and a register write can coincide. A step can also land on a position whose rounding reaches the next source sample. The bench drives start and step together on a running line and expects the start position with no advance flag. It writes a new ratio in the same cycle as a start and expects the following step to use the old ratio. It loads a fraction just below 1.0 and expects phase 0 on the next source index.

// File: rtl/psg_pkg.sv
package psg_pkg;

    parameter int FRAC_W      = 24;
    parameter int RATIO_INT_W = 3;
    parameter int INIT_INT_W  = 4;
    parameter int IDX_W       = 16;
    parameter int PHASE_W     = 6;
    parameter int PAD_W       = 5;
    parameter int ADDR_W      = 3;
    parameter int NUM_PLANES  = 2;
    parameter int NUM_FIELDS  = 2;

    localparam int REG_W        = INIT_INT_W + FRAC_W;
    localparam int RATIO_W      = RATIO_INT_W + FRAC_W;
    localparam int ACC_W        = IDX_W + FRAC_W;
    localparam int NUM_STARTS   = NUM_PLANES * NUM_FIELDS;
    localparam int A_RATIO_BASE = 0;
    localparam int A_INIT_BASE  = A_RATIO_BASE + NUM_PLANES;
    localparam logic [FRAC_W:0] HALF_PHASE = (FRAC_W+1)'(1) << (FRAC_W - PHASE_W - 1);

    typedef enum logic { PLANE_Y = 1'b0, PLANE_C = 1'b1 } plane_e;
    typedef enum logic { FIELD_TOP = 1'b0, FIELD_BOT = 1'b1 } field_e;

    typedef struct packed {
        logic [RATIO_INT_W-1:0] ip;
        logic [FRAC_W-1:0]      fp;
    } ratio_t;

    typedef struct packed {
        logic [INIT_INT_W-1:0] ip;
        logic [FRAC_W-1:0]     fp;
    } start_pos_t;

    typedef struct packed {
        logic [IDX_W-1:0]   idx;
        logic [PHASE_W-1:0] phase;
    } tap_pos_t;

    function automatic logic [FRAC_W-1:0] clr_pad(input logic [FRAC_W-1:0] f);
        return {f[FRAC_W-1:PAD_W], {PAD_W{1'b0}}};
    endfunction

    // returns {round carry, phase}
    function automatic logic [PHASE_W:0] round_phase(input logic [FRAC_W-1:0] f);
        logic [FRAC_W:0] s;
        s = {1'b0, f} + HALF_PHASE;
        return s[FRAC_W -: (PHASE_W + 1)];
    endfunction

endpackage

// File: rtl/psg_cfg_regs.sv
module psg_cfg_regs
    import psg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  plane_e            plane,
    input  field_e            field,
    output ratio_t            ratio_sel,
    output start_pos_t        start_sel
);

    ratio_t     ratio_q [NUM_PLANES];
    start_pos_t start_q [NUM_STARTS];

    for (genvar p = 0; p < NUM_PLANES; p++) begin : g_ratio
        always_ff @(posedge clk) begin
            if (rst) begin
                ratio_q[p] <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(A_RATIO_BASE + p)) begin
                ratio_q[p].ip <= wr_data[FRAC_W +: RATIO_INT_W];
                ratio_q[p].fp <= clr_pad(wr_data[FRAC_W-1:0]);
            end
        end
    end

    for (genvar s = 0; s < NUM_STARTS; s++) begin : g_start
        always_ff @(posedge clk) begin
            if (rst) begin
                start_q[s] <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(A_INIT_BASE + s)) begin
                start_q[s].ip <= wr_data[FRAC_W +: INIT_INT_W];
                start_q[s].fp <= clr_pad(wr_data[FRAC_W-1:0]);
            end
        end
    end

    always_comb begin
        ratio_sel = ratio_q[plane];
        start_sel = start_q[{plane, field}];
    end

endmodule

// File: rtl/psg_accum.sv
module psg_accum
    import psg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              step,
    input  ratio_t            ratio_in,
    input  start_pos_t        start_in,
    output logic [IDX_W-1:0]  pos_int,
    output logic [FRAC_W-1:0] pos_frac,
    output logic              running,
    output logic              moved
);

    ratio_t           ratio_run_q;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_next;
    logic             int_changed;

    always_comb begin
        acc_next    = acc_q + ACC_W'(ratio_run_q);
        int_changed = acc_next[ACC_W-1:FRAC_W] != acc_q[ACC_W-1:FRAC_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q       <= '0;
            ratio_run_q <= '0;
            running     <= 1'b0;
            moved       <= 1'b0;
        end else if (start) begin
            acc_q       <= ACC_W'(start_in);
            ratio_run_q <= ratio_in;
            running     <= 1'b1;
            moved       <= 1'b0;
        end else if (step && running) begin
            acc_q <= acc_next;
            moved <= int_changed;
        end else begin
            moved <= 1'b0;
        end
    end

    assign pos_int  = acc_q[ACC_W-1:FRAC_W];
    assign pos_frac = acc_q[FRAC_W-1:0];

endmodule

// File: rtl/psg_phase_quant.sv
module psg_phase_quant
    import psg_pkg::*;
(
    input  logic [IDX_W-1:0]  pos_int,
    input  logic [FRAC_W-1:0] pos_frac,
    output tap_pos_t          tap
);

    logic [PHASE_W:0] rp;

    always_comb begin
        rp        = round_phase(pos_frac);
        tap.phase = rp[PHASE_W-1:0];
        tap.idx   = pos_int + IDX_W'(rp[PHASE_W]);
    end

endmodule

// File: rtl/scaler_phase_gen.sv
module scaler_phase_gen
    import psg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               start_i,
    input  logic               sel_chroma_i,
    input  logic               sel_bottom_i,
    input  logic               step_i,
    output logic [IDX_W-1:0]   src_idx_o,
    output logic [PHASE_W-1:0] phase_o,
    output logic               advance_o,
    output logic               active_o
);

    ratio_t            ratio_cur;
    start_pos_t        start_cur;
    logic [IDX_W-1:0]  pos_int;
    logic [FRAC_W-1:0] pos_frac;
    tap_pos_t          tap;
    plane_e            plane;
    field_e            field;

    assign plane = plane_e'(sel_chroma_i);
    assign field = field_e'(sel_bottom_i);

    psg_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .plane     (plane),
        .field     (field),
        .ratio_sel (ratio_cur),
        .start_sel (start_cur)
    );

    psg_accum u_acc (
        .clk      (clk),
        .rst      (rst),
        .start    (start_i),
        .step     (step_i),
        .ratio_in (ratio_cur),
        .start_in (start_cur),
        .pos_int  (pos_int),
        .pos_frac (pos_frac),
        .running  (active_o),
        .moved    (advance_o)
    );

    psg_phase_quant u_quant (
        .pos_int  (pos_int),
        .pos_frac (pos_frac),
        .tap      (tap)
    );

    assign src_idx_o = tap.idx;
    assign phase_o   = tap.phase;

endmodule

// File: rtl/psg_checker.sv
module psg_checker
    import psg_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               start_i,
    input logic               step_i,
    input logic [IDX_W-1:0]   src_idx_o,
    input logic [PHASE_W-1:0] phase_o,
    input logic               advance_o,
    input logic               active_o,
    input logic [PAD_W-1:0]   ratio_pad,
    input logic [PAD_W-1:0]   start_pad
);

    // R2: stored low fraction bits stay clear
    p_pad_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (ratio_pad == '0) && (start_pad == '0));

    // R4: outputs hold without step or start
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (active_o && !start_i && !step_i) |=>
            ($stable(src_idx_o) && $stable(phase_o) && !advance_o));

    // R4: advance only follows an accepted step
    p_advance_cause_r4: assert property (@(posedge clk) disable iff (rst)
        advance_o |-> $past(step_i && !start_i && active_o));

    // R7 / R3: start activates and suppresses the advance flag
    p_start_wins_r7: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (active_o && !advance_o));

    // R8: idle steps change nothing
    p_idle_step_r8: assert property (@(posedge clk) disable iff (rst)
        (!active_o && !start_i) |=>
            ($stable(src_idx_o) && $stable(phase_o) && !advance_o && !active_o));

endmodule

bind scaler_phase_gen psg_checker i_psg_checker (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .step_i    (step_i),
    .src_idx_o (src_idx_o),
    .phase_o   (phase_o),
    .advance_o (advance_o),
    .active_o  (active_o),
    .ratio_pad (ratio_cur.fp[psg_pkg::PAD_W-1:0]),
    .start_pad (start_cur.fp[psg_pkg::PAD_W-1:0])
);

// File: tb/test_scaler_phase_gen.sv
module test_scaler_phase_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [27:0] wr_data = '0;
    logic        start_i = 1'b0;
    logic        sel_chroma_i = 1'b0;
    logic        sel_bottom_i = 1'b0;
    logic        step_i = 1'b0;
    logic [15:0] src_idx_o;
    logic [5:0]  phase_o;
    logic        advance_o;
    logic        active_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    localparam int NV = 6;
    localparam logic [26:0] V_RATIO [NV] = '{27'h1000000, 27'h0800000, 27'h2400000,
                                             27'h04CCCCC, 27'h7FFFFFF, 27'h0C00000};
    localparam logic [3:0]  V_IINT  [NV] = '{4'd0, 4'd0, 4'd1, 4'd0, 4'd15, 4'd3};
    localparam logic [23:0] V_IFRAC [NV] = '{24'h000000, 24'h000000, 24'h400000,
                                             24'h123456, 24'hFFFFE0, 24'hFF0000};
    localparam int          V_STEPS [NV] = '{5, 6, 4, 8, 4, 5};

    scaler_phase_gen i_scaler_phase_gen (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .start_i(start_i), .sel_chroma_i(sel_chroma_i), .sel_bottom_i(sel_bottom_i),
        .step_i(step_i), .src_idx_o(src_idx_o), .phase_o(phase_o),
        .advance_o(advance_o), .active_o(active_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input longint got, input longint exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic longint exp_idx(input longint pos);
        return ((pos + 64'h20000) >> 24) & 64'hFFFF;
    endfunction

    function automatic longint exp_ph(input longint pos);
        return ((pos + 64'h20000) >> 18) & 64'h3F;
    endfunction

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wreg(input logic [2:0] a, input logic [27:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pulse(input bit s, input bit st, input bit c, input bit b);
        start_i = s; step_i = st; sel_chroma_i = c; sel_bottom_i = b;
        tick();
        start_i = 1'b0; step_i = 1'b0;
    endtask

    task automatic chk_pos(input string req, input longint pos);
        chk({req, " idx"}, src_idx_o, exp_idx(pos));
        chk({req, " phase"}, phase_o, exp_ph(pos));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        longint pos, old, rat;
        repeat (3) @(posedge clk);
        #2;
        // R1 during reset
        chk("R1 idx in reset", src_idx_o, 0);
        rst = 1'b0;
        tick();
        chk("R1 idx", src_idx_o, 0);
        chk("R1 phase", phase_o, 0);
        chk("R1 advance", advance_o, 0);
        chk("R1 active", active_o, 0);

        // R8: step while idle
        wreg(3'd0, 28'h1000000);
        pulse(0, 1, 0, 0);
        chk("R8 idx", src_idx_o, 0);
        chk("R8 active", active_o, 0);
        chk("R8 advance", advance_o, 0);

        // Table walk: R3, R4, R5 on luma top
        for (int v = 0; v < NV; v++) begin
            wreg(3'd0, {1'b0, V_RATIO[v]});
            wreg(3'd2, {V_IINT[v], V_IFRAC[v]});
            pulse(1, 0, 0, 0);
            pos = (longint'(V_IINT[v]) << 24) | (longint'(V_IFRAC[v]) & ~64'h1F);
            rat = longint'(V_RATIO[v]) & ~64'h1F;
            chk_pos("R3 start", pos);
            chk("R3 active", active_o, 1);
            for (int s = 0; s < V_STEPS[v]; s++) begin
                pulse(0, 1, 0, 0);
                old = pos;
                pos = pos + rat;
                chk_pos("R4 step", pos);
                chk("R4 advance", advance_o, ((pos >> 24) != (old >> 24)) ? 1 : 0);
            end
            tick();
            chk_pos("R4 hold", pos);
            chk("R4 advance clear", advance_o, 0);
        end

        // R5: rounding reaches the next source sample
        wreg(3'd2, {4'd3, 24'hFE0000});
        pulse(1, 0, 0, 0);
        chk("R5 idx carry", src_idx_o, 4);
        chk("R5 phase wrap", phase_o, 0);
        wreg(3'd2, {4'd3, 24'hFDFFE0});
        pulse(1, 0, 0, 0);
        chk("R5 idx below", src_idx_o, 3);
        chk("R5 phase 63", phase_o, 63);

        // R6: plane and field selection
        wreg(3'd0, 28'h0C00000);
        wreg(3'd1, 28'h0800000);
        wreg(3'd4, {4'd5, 24'h000000});
        wreg(3'd5, {4'd9, 24'h800000});
        wreg(3'd3, {4'd2, 24'h000000});
        pulse(1, 0, 1, 1);
        chk("R6 chroma bot idx", src_idx_o, 9);
        chk("R6 chroma bot phase", phase_o, 32);
        pulse(0, 1, 0, 0);
        chk("R6 chroma ratio idx", src_idx_o, 10);
        chk("R6 chroma ratio phase", phase_o, 0);
        chk("R6 chroma advance", advance_o, 1);
        pulse(1, 0, 1, 0);
        chk("R6 chroma top idx", src_idx_o, 5);
        pulse(1, 0, 0, 1);
        chk("R6 luma bot idx", src_idx_o, 2);
        pulse(0, 1, 0, 0);
        chk("R6 luma ratio idx", src_idx_o, 2);
        chk("R6 luma ratio phase", phase_o, 48);

        // R7: start and step together
        pulse(0, 1, 0, 1);
        pulse(1, 1, 0, 1);
        chk("R7 idx", src_idx_o, 2);
        chk("R7 phase", phase_o, 0);
        chk("R7 advance", advance_o, 0);

        // R10: write coinciding with start, and mid-line ratio write
        wreg(3'd0, 28'h1000000);
        wreg(3'd2, 28'h0000000);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 28'h0800000;
        pulse(1, 0, 0, 0);
        wr_en = 1'b0;
        pulse(0, 1, 0, 0);
        chk("R10 old ratio idx", src_idx_o, 1);
        chk("R10 old ratio phase", phase_o, 0);
        wreg(3'd0, 28'h2000000);
        pulse(0, 1, 0, 0);
        chk("R10 mid-line idx", src_idx_o, 2);
        pulse(1, 0, 0, 0);
        pulse(0, 1, 0, 0);
        chk("R10 new ratio idx", src_idx_o, 2);

        // R9: unmapped addresses
        wreg(3'd0, 28'h0800000);
        wreg(3'd6, 28'hFFFFFFF);
        wreg(3'd7, 28'hFFFFFFF);
        pulse(1, 0, 0, 0);
        chk("R9 start idx", src_idx_o, 0);
        chk("R9 start phase", phase_o, 0);
        pulse(0, 1, 0, 0);
        chk("R9 ratio phase", phase_o, 32);

        // R2: pad bits of the ratio discarded
        wreg(3'd0, 28'h000001F);
        wreg(3'd2, {4'd0, 24'h01FFE0});
        pulse(1, 0, 0, 0);
        pulse(0, 1, 0, 0);
        pulse(0, 1, 0, 0);
        chk("R2 phase", phase_o, 0);
        chk("R2 idx", src_idx_o, 0);

        // R1 again: reset mid-line
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R1 active after reset", active_o, 0);
        chk("R1 phase after reset", phase_o, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule